// File: doc/BRIEF.md
# Low-Order Interleaved Memory Bank Router

This block sits between a processor's memory port and a set of word-wide memory banks, each served by its own small controller. A request carries a byte address. The router takes that address apart by slicing bits. The lowest bits give the byte lane within a 32-bit word. The next bits choose the bank. The remaining upper bits give the row inside that bank. As a result, neighbouring words fall into neighbouring banks, and a stream of sequential accesses keeps every bank working at the same time.

Each bank handles one access at a time and takes a fixed number of cycles for it. A request to an idle bank is taken at once. A request to a busy bank holds the port with ready low until that bank has delivered its response. Every accepted request produces one response. A small queue of bank indices remembers the issue order, so responses come out in exactly the order the requests went in, even though several banks overlap. The bank side always moves whole words. A single-byte store is carried out as a read of the word, a merge of the new byte, and a write of the whole word back.

Top module: `ilv_bank_router`

## Requirements
- R1: For byte address A, the byte lane is A[1:0], the bank is A[2 +: log2(NUM_BANKS)] and the row is the bits above those. The bank controller of the chosen bank drives that row on its memory address while it runs the access.
- R2: `req_ready` is high exactly when the addressed bank has no access outstanding. A bank becomes free on the clock edge at which its response is delivered. A request to a busy bank therefore waits BANK_LAT+1 cycles behind an access accepted just before it.
- R3: When a request's response is at the head of the order, `rsp_valid` is high in the cycle that follows the BANK_LAT-th clock edge after acceptance, for exactly one cycle.
- R4: Responses leave in the order the requests were accepted, one response per request.
- R5: A read (`req_write`=0) returns the whole stored word. The lane bits A[1:0] have no effect on it.
- R6: A word write (`req_write`=1, `req_byte`=0) stores all 32 bits of `req_wdata`. Its response carries the word as written.
- R7: A byte write (`req_write`=1, `req_byte`=1) replaces only byte lane A[1:0] (bits 8*lane+7 down to 8*lane) with `req_wdata[7:0]` and keeps the other three bytes. Its response carries the merged word.
- R8: Requests to different banks on back-to-back cycles are all accepted without a stall while earlier banks are still busy.
- R9: After reset, `req_ready` is high, `rsp_valid` is low and no bank memory enable is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Addressed bank can take the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | With a write: 1 = single byte, 0 = whole word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write word; bits 7:0 are the byte for a byte write |
| rsp_valid | output | 1 | Response word present for one cycle |
| rsp_rdata | output | 32 | Word read, or word as written |
| mem_en | output | NUM_BANKS | Per-bank memory access enable |
| mem_we | output | NUM_BANKS | Per-bank write enable, valid with mem_en |
| mem_addr | output | NUM_BANKS*(ADDR_W-2-log2(NUM_BANKS)) | Per-bank row address, bank i in slice i |
| mem_wdata | output | NUM_BANKS*32 | Per-bank write word |
| mem_rdata | input | NUM_BANKS*32 | Per-bank read word, valid the cycle after a read enable |

## Verification
The assertions take it for granted that each bank array returns its read word on the cycle after a read enable and has no stall of its own. They also assume BANK_LAT is at least three, which leaves room for the read, the capture and the final write. They further assume that a waiting request keeps its address and fields unchanged until it is accepted, because the ready signal is worked out from the address presented. The bench's bank models answer with that one-cycle read timing. Its request task holds every field steady until the acceptance edge.

// File: rtl/ilv_pkg.sv
// Shared word geometry, bank controller state and per-access operation record.
// Assumes a 32-bit word, so the byte-lane field is two bits wide.
package ilv_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int OFF_W      = $clog2(WORD_BYTES);

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_RD,
        BK_CAP,
        BK_WAIT,
        BK_FIN,
        BK_DONE
    } bank_state_e;

    typedef struct packed {
        logic              is_write;
        logic              is_byte;
        logic [OFF_W-1:0]  lane;
        logic [WORD_W-1:0] wdata;
    } bank_op_t;

    // Replace one byte lane of a word with a new byte.
    function automatic logic [WORD_W-1:0] merge_lane(
        input logic [WORD_W-1:0] old_word,
        input logic [OFF_W-1:0]  lane,
        input logic [7:0]        new_byte
    );
        logic [WORD_W-1:0] w;
        w = old_word;
        w[{lane, 3'b000} +: 8] = new_byte;
        return w;
    endfunction
endpackage

// File: rtl/ilv_addr_split.sv
// Splits a byte address into lane, bank select and row by slicing bits.
// Assumes ADDR_W equals lane bits + select bits + row bits.
module ilv_addr_split
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SEL_W  = 2,
    parameter int ROW_W  = ADDR_W - OFF_W - SEL_W
) (
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [OFF_W-1:0]  lane,
    output logic [SEL_W-1:0]  sel,
    output logic [ROW_W-1:0]  row
);
    // Fixed field extraction, no arithmetic.
    assign lane = byte_addr[OFF_W-1:0];
    assign sel  = byte_addr[OFF_W +: SEL_W];
    assign row  = byte_addr[OFF_W+SEL_W +: ROW_W];
endmodule

// File: rtl/ilv_bank_ctrl.sv
// Controller for one bank: read the word, wait out the fixed latency,
// write back a merged or replaced word for stores, then hold the result
// until the response stage releases it.
// Assumes the array returns read data one cycle after a read enable and
// that BANK_LAT is at least 3.
module ilv_bank_ctrl
    import ilv_pkg::*;
#(
    parameter int ROW_W    = 8,
    parameter int BANK_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  bank_op_t          op_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic              release_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] result_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ROW_W-1:0]  mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i
);
    localparam int CNT_W = $clog2(BANK_LAT + 1);
    localparam logic [CNT_W-1:0] WAIT_N = CNT_W'(BANK_LAT - 3);

    bank_state_e       state_q;
    bank_op_t          op_q;
    logic [ROW_W-1:0]  row_q;
    logic [WORD_W-1:0] old_q;
    logic [WORD_W-1:0] result_q;
    logic [CNT_W-1:0]  wait_q;
    logic [WORD_W-1:0] new_word;

    // Word that the access leaves in the array and reports back.
    always_comb begin
        if (!op_q.is_write)
            new_word = old_q;
        else if (op_q.is_byte)
            new_word = merge_lane(old_q, op_q.lane, op_q.wdata[7:0]);
        else
            new_word = op_q.wdata;
    end

    // Access sequencing from acceptance to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= BK_IDLE;
            op_q     <= '0;
            row_q    <= '0;
            old_q    <= '0;
            result_q <= '0;
            wait_q   <= '0;
        end else begin
            case (state_q)
                BK_IDLE: begin
                    if (start_i) begin
                        op_q    <= op_i;
                        row_q   <= row_i;
                        state_q <= BK_RD;
                    end
                end
                BK_RD:   state_q <= BK_CAP;
                BK_CAP: begin
                    old_q   <= mem_rdata_i;
                    wait_q  <= WAIT_N;
                    state_q <= (WAIT_N == '0) ? BK_FIN : BK_WAIT;
                end
                BK_WAIT: begin
                    wait_q <= wait_q - 1'b1;
                    if (wait_q == CNT_W'(1))
                        state_q <= BK_FIN;
                end
                BK_FIN: begin
                    result_q <= new_word;
                    state_q  <= BK_DONE;
                end
                BK_DONE: begin
                    if (release_i)
                        state_q <= BK_IDLE;
                end
                default: state_q <= BK_IDLE;
            endcase
        end
    end

    // Array strobes: read on entry, write-back on the final step of a store.
    assign mem_en_o    = (state_q == BK_RD) || ((state_q == BK_FIN) && op_q.is_write);
    assign mem_we_o    = (state_q == BK_FIN) && op_q.is_write;
    assign mem_addr_o  = row_q;
    assign mem_wdata_o = new_word;

    // Status towards the router.
    assign busy_o   = (state_q != BK_IDLE);
    assign done_o   = (state_q == BK_DONE);
    assign result_o = result_q;
endmodule

// File: rtl/ilv_order_fifo.sv
// Circular queue of bank indices recording issue order.
// Assumes DEPTH is a power of two and that the producer never pushes
// into a full queue (one entry per busy bank at most).
module ilv_order_fifo #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_idx;
    end

    assign head_idx = slots[rd_ptr];
    assign empty    = (count == '0);
endmodule

// File: rtl/ilv_bank_router.sv
// Top of the interleaved bank router: decodes the byte address, starts
// the selected bank when it is idle, and returns results in issue order.
// Assumes NUM_BANKS is a power of two (at least 2) and BANK_LAT >= 3.
module ilv_bank_router
    import ilv_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 4,
    parameter int BANK_LAT  = 4
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              req_valid,
    output logic                                              req_ready,
    input  logic                                              req_write,
    input  logic                                              req_byte,
    input  logic [ADDR_W-1:0]                                 req_addr,
    input  logic [WORD_W-1:0]                                 req_wdata,
    output logic                                              rsp_valid,
    output logic [WORD_W-1:0]                                 rsp_rdata,
    output logic [NUM_BANKS-1:0]                              mem_en,
    output logic [NUM_BANKS-1:0]                              mem_we,
    output logic [NUM_BANKS*(ADDR_W-OFF_W-$clog2(NUM_BANKS))-1:0] mem_addr,
    output logic [NUM_BANKS*WORD_W-1:0]                       mem_wdata,
    input  logic [NUM_BANKS*WORD_W-1:0]                       mem_rdata
);
    localparam int SEL_W     = $clog2(NUM_BANKS);
    localparam int ROW_W     = ADDR_W - OFF_W - SEL_W;
    localparam int ORD_CNT_W = $clog2(NUM_BANKS + 1);

    logic [OFF_W-1:0]     req_lane;
    logic [SEL_W-1:0]     req_sel;
    logic [ROW_W-1:0]     req_row;
    bank_op_t             req_op;
    logic                 req_fire;
    logic [NUM_BANKS-1:0] bank_busy;
    logic [NUM_BANKS-1:0] bank_done;
    logic [NUM_BANKS-1:0] bank_start;
    logic [NUM_BANKS-1:0] bank_release;
    logic [WORD_W-1:0]    bank_result [NUM_BANKS];
    logic [SEL_W-1:0]     ord_head;
    logic                 ord_empty;
    logic [ORD_CNT_W-1:0] ord_count;

    ilv_addr_split #(
        .ADDR_W (ADDR_W),
        .SEL_W  (SEL_W),
        .ROW_W  (ROW_W)
    ) u_split (
        .byte_addr (req_addr),
        .lane      (req_lane),
        .sel       (req_sel),
        .row       (req_row)
    );

    // Operation record handed to the selected bank.
    assign req_op = '{is_write: req_write, is_byte: req_byte,
                      lane: req_lane, wdata: req_wdata};

    // Accept only when the addressed bank is free.
    assign req_ready = !bank_busy[req_sel];
    assign req_fire  = req_valid && req_ready;

    // Response comes from the oldest issued bank once it has finished.
    assign rsp_valid = !ord_empty && bank_done[ord_head];
    assign rsp_rdata = bank_result[ord_head];

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        assign bank_start[i]   = req_fire && (req_sel == SEL_W'(i));
        assign bank_release[i] = rsp_valid && (ord_head == SEL_W'(i));

        ilv_bank_ctrl #(
            .ROW_W    (ROW_W),
            .BANK_LAT (BANK_LAT)
        ) u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_i     (bank_start[i]),
            .op_i        (req_op),
            .row_i       (req_row),
            .release_i   (bank_release[i]),
            .busy_o      (bank_busy[i]),
            .done_o      (bank_done[i]),
            .result_o    (bank_result[i]),
            .mem_en_o    (mem_en[i]),
            .mem_we_o    (mem_we[i]),
            .mem_addr_o  (mem_addr[i*ROW_W +: ROW_W]),
            .mem_wdata_o (mem_wdata[i*WORD_W +: WORD_W]),
            .mem_rdata_i (mem_rdata[i*WORD_W +: WORD_W])
        );
    end

    ilv_order_fifo #(
        .DEPTH (NUM_BANKS),
        .IDX_W (SEL_W),
        .CNT_W (ORD_CNT_W)
    ) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (req_fire),
        .push_idx (req_sel),
        .pop      (rsp_valid),
        .head_idx (ord_head),
        .empty    (ord_empty),
        .count    (ord_count)
    );
endmodule

// File: rtl/ilv_bank_router_chk.sv
// Property checker for the bank router, attached to every instance by bind.
// Assumes the bank arrays answer reads one cycle after the enable.
module ilv_bank_router_chk #(
    parameter int NUM_BANKS = 4,
    parameter int SEL_W     = 2,
    parameter int CNT_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [SEL_W-1:0]     req_sel,
    input logic [NUM_BANKS-1:0] bank_busy,
    input logic                 rsp_valid,
    input logic [CNT_W-1:0]     ord_count,
    input logic [SEL_W-1:0]     ord_head,
    input logic [NUM_BANKS-1:0] mem_en
);
    // R2: an accepted request leaves its bank busy on the next cycle.
    p_accept_marks_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bank_busy[$past(req_sel)])
        else $error("p_accept_marks_busy_r2");

    // R4: the order queue holds exactly one entry per busy bank.
    p_queue_tracks_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ord_count) == $countones(bank_busy))
        else $error("p_queue_tracks_busy_r4");

    // R4: a response frees the bank it came from.
    p_release_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !bank_busy[$past(ord_head)])
        else $error("p_release_frees_r4");

    // R4: no response without an issued request.
    p_rsp_has_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (ord_count != '0))
        else $error("p_rsp_has_entry_r4");

    // R1: a bank touches its array only while it owns an access.
    p_mem_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en & ~bank_busy) == '0)
        else $error("p_mem_only_busy_r1");
endmodule

bind ilv_bank_router ilv_bank_router_chk #(
    .NUM_BANKS (NUM_BANKS),
    .SEL_W     (SEL_W),
    .CNT_W     (ORD_CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_sel   (req_sel),
    .bank_busy (bank_busy),
    .rsp_valid (rsp_valid),
    .ord_count (ord_count),
    .ord_head  (ord_head),
    .mem_en    (mem_en)
);

// File: tb/tb_ilv_bank_router.sv
// Bench: bank array models, a behavioural per-cycle reference model with a
// queue and counters, directed cases and a random mix.
`timescale 1ns/1ps
module tb_ilv_bank_router;
    localparam int ADDR_W    = 12;
    localparam int NUM_BANKS = 4;
    localparam int BANK_LAT  = 4;
    localparam int SEL_W     = $clog2(NUM_BANKS);
    localparam int ROW_W     = ADDR_W - 2 - SEL_W;
    localparam int ROWS      = 1 << ROW_W;
    localparam int WORDS     = ROWS * NUM_BANKS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic req_byte = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NUM_BANKS-1:0] mem_en;
    logic [NUM_BANKS-1:0] mem_we;
    logic [NUM_BANKS*ROW_W-1:0] mem_addr;
    logic [NUM_BANKS*32-1:0] mem_wdata;
    logic [NUM_BANKS*32-1:0] mem_rdata;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    ilv_bank_router #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .BANK_LAT  (BANK_LAT)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_byte  (req_byte),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [31:0] init_word(input int wa);
        return (32'(wa) * 32'h0102_0305) ^ 32'h5A5A_0000;
    endfunction

    // Bank arrays: read data one cycle after a read enable.
    logic [31:0] bmem [NUM_BANKS][ROWS];
    logic [31:0] rd_q [NUM_BANKS];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                rd_q[b] <= '0;
                for (int r = 0; r < ROWS; r++) bmem[b][r] <= init_word(r * NUM_BANKS + b);
            end
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (mem_en[b]) begin
                    if (mem_we[b]) bmem[b][mem_addr[b*ROW_W +: ROW_W]] <= mem_wdata[b*32 +: 32];
                    else rd_q[b] <= bmem[b][mem_addr[b*ROW_W +: ROW_W]];
                end
            end
        end
    end
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) mem_rdata[b*32 +: 32] = rd_q[b];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model state.
    bit          m_busy [NUM_BANKS];
    bit          m_done [NUM_BANKS];
    int          m_cnt  [NUM_BANKS];
    int          m_row  [NUM_BANKS];
    logic [31:0] m_res  [NUM_BANKS];
    string       m_tag  [NUM_BANKS];
    int          m_q [$];
    logic [31:0] ref_mem [WORDS];

    // Model update on each rising edge, from pre-edge inputs.
    always @(posedge clk) begin
        int  wa;
        int  b;
        int  lane;
        bit  acc;
        logic [31:0] w;
        if (!rst_n) begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                m_busy[i] = 0; m_done[i] = 0; m_cnt[i] = 0; m_row[i] = 0;
            end
            m_q.delete();
            for (int i = 0; i < WORDS; i++) ref_mem[i] = init_word(i);
        end else begin
            wa   = int'(req_addr) >> 2;
            b    = wa % NUM_BANKS;
            lane = int'(req_addr) % 4;
            acc  = req_valid && !m_busy[b];
            if (m_q.size() > 0 && m_done[m_q[0]]) begin
                m_busy[m_q[0]] = 0;
                m_done[m_q[0]] = 0;
                void'(m_q.pop_front());
            end
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (m_busy[i] && !m_done[i]) begin
                    m_cnt[i]--;
                    if (m_cnt[i] == 0) m_done[i] = 1;
                end
            end
            if (acc) begin
                w = ref_mem[wa];
                if (!req_write) m_tag[b] = "R5";
                else if (req_byte) begin
                    w[lane*8 +: 8] = req_wdata[7:0];
                    m_tag[b] = "R7";
                end else begin
                    w = req_wdata;
                    m_tag[b] = "R6";
                end
                ref_mem[wa] = w;
                m_res[b]  = w;
                m_row[b]  = wa / NUM_BANKS;
                m_busy[b] = 1;
                m_done[b] = 0;
                m_cnt[b]  = BANK_LAT;
                m_q.push_back(b);
            end
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        bit exp_v;
        int b;
        #1;
        if (rst_n) begin
            b = (int'(req_addr) >> 2) % NUM_BANKS;
            chk(req_ready == !m_busy[b], "R2", "req_ready", 32'(req_ready), 32'(!m_busy[b]));
            exp_v = (m_q.size() > 0) && m_done[m_q[0]];
            chk(rsp_valid == exp_v, "R3", "rsp_valid", 32'(rsp_valid), 32'(exp_v));
            if (exp_v && rsp_valid)
                chk(rsp_rdata == m_res[m_q[0]], {m_tag[m_q[0]], " R4"}, "rsp_rdata",
                    rsp_rdata, m_res[m_q[0]]);
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (mem_en[i])
                    chk(int'(mem_addr[i*ROW_W +: ROW_W]) == m_row[i], "R1", "mem_addr",
                        32'(mem_addr[i*ROW_W +: ROW_W]), 32'(m_row[i]));
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected <= 50000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Present a request, hold it until accepted, count stalled cycles.
    task automatic issue(input bit wr, input bit by, input int addr,
                         input logic [31:0] wd, output int stalls);
        req_valid = 1'b1;
        req_write = wr;
        req_byte  = by;
        req_addr  = ADDR_W'(addr);
        req_wdata = wd;
        stalls    = 0;
        #2;
        while (!req_ready) begin
            @(negedge clk);
            #2;
            stalls++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Wait for a response; returns its data and the cycles waited.
    task automatic wait_rsp(output logic [31:0] d, output int n);
        n = 0;
        #2;
        while (!rsp_valid) begin
            @(negedge clk);
            #2;
            n++;
        end
        d = rsp_rdata;
    endtask

    task automatic drain();
        repeat (BANK_LAT + 6) @(negedge clk);
    endtask

    initial begin
        int st;
        int n;
        logic [31:0] d;
        logic [31:0] d2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R9: reset state
        chk(req_ready == 1'b1, "R9", "req_ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk(mem_en == '0, "R9", "mem_en after reset", 32'(mem_en), 32'd0);
        @(negedge clk);

        // R8: consecutive words go to different banks with no stall
        for (int k = 0; k < NUM_BANKS; k++) begin
            issue(1'b0, 1'b0, k * 4, 32'h0, st);
            chk(st == 0, "R8", "stalls on sequential words", 32'(st), 32'd0);
        end
        drain();

        // R2: second access to the same bank waits BANK_LAT+1 cycles
        issue(1'b0, 1'b0, 32'h40, 32'h0, st);
        issue(1'b0, 1'b0, 32'h80, 32'h0, st);
        chk(st == BANK_LAT + 1, "R2", "stalls behind busy bank", 32'(st), 32'(BANK_LAT + 1));
        drain();

        // R3: latency from acceptance to response
        issue(1'b0, 1'b0, 32'h104, 32'h0, st);
        wait_rsp(d, n);
        chk(n == BANK_LAT, "R3", "response latency", 32'(n), 32'(BANK_LAT));
        drain();

        // R6 then R5: word write, read back with a nonzero lane
        issue(1'b1, 1'b0, 32'h208, 32'hDEAD_BEEF, st);
        drain();
        issue(1'b0, 1'b0, 32'h20B, 32'h0, st);
        wait_rsp(d, n);
        chk(d == 32'hDEAD_BEEF, "R5", "read ignores lane bits", d, 32'hDEAD_BEEF);
        drain();

        // R7: byte write into lane 1
        issue(1'b1, 1'b1, 32'h209, 32'hFFFF_FF77, st);
        drain();
        issue(1'b0, 1'b0, 32'h208, 32'h0, st);
        wait_rsp(d, n);
        chk(d == 32'hDEAD_77EF, "R7", "byte merge lane 1", d, 32'hDEAD_77EF);
        drain();

        // R7: byte write into lane 3 and lane 0
        issue(1'b1, 1'b1, 32'h20B, 32'h0000_0011, st);
        issue(1'b1, 1'b1, 32'h30C, 32'h0000_0022, st);
        drain();
        issue(1'b0, 1'b0, 32'h208, 32'h0, st);
        wait_rsp(d, n);
        chk(d == 32'h11AD_77EF, "R7", "byte merge lane 3", d, 32'h11AD_77EF);
        drain();

        // R4: two banks, responses in issue order
        issue(1'b0, 1'b0, 32'h08, 32'h0, st);
        issue(1'b0, 1'b0, 32'h0C, 32'h0, st);
        wait_rsp(d, n);
        @(negedge clk);
        wait_rsp(d2, n);
        chk(d == init_word(2), "R4", "first response", d, init_word(2));
        chk(d2 == init_word(3), "R4", "second response", d2, init_word(3));
        drain();

        // Random mix over a small window to force bank conflicts
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom_range(0, 3);
            issue(r == 2 || r == 3, r == 3, $urandom_range(0, 255), $urandom, st);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        drain();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule